// File: doc/BRIEF.md
# Instruction Trailing-Byte Assembler

This block gathers the bytes that follow the addressing stage of a variable-length instruction and turns them into two 32-bit values: an address displacement and an immediate operand. A `start` pulse loads the size of each field together with the current data size and two extension controls. After that the block accepts one byte on each cycle in which `byte_valid` is high. The displacement bytes arrive first and the immediate bytes follow them. All bytes go into one little-endian accumulator.

Once the last required byte has been taken, the block raises `done` for one cycle and presents both values. It then clears itself. While it is collecting, `bytes_left` shows how many bytes it still needs, so the fetch logic can tell when the stream ran out before the instruction was complete.

Top module: `asm_trail`

## Requirements
- R1: Size codes on `disp_size`, `imm_size` and `data_size` are 0 = none, 1 = one byte, 2 = two bytes, 3 = four bytes. The number of bytes collected is the displacement byte count plus the immediate byte count.
- R2: Bytes are stored little-endian. The first accepted byte becomes bits 7:0 and each later byte sits 8 bits above the one before it.
- R3: The displacement comes from the lowest bytes of the accumulator. The immediate comes from the bytes that follow the displacement.
- R4: A one- or two-byte displacement is sign-extended to 32 bits when `disp_sext` is 1 and zero-extended when it is 0. A four-byte displacement is passed through unchanged.
- R5: The immediate is sign-extended from its width only when `imm_sext` is 1 and `imm_size` differs from `data_size`. In every other case it is zero-extended.
- R6: While collecting, `bytes_left` equals the required count minus the bytes accepted so far. A cycle with `byte_valid` low leaves it unchanged.
- R7: `done` is high for exactly one cycle, in the cycle after the final byte is accepted. `disp_out` and `imm_out` carry the results only while `done` is high and are zero at all other times.
- R8: When both field sizes are none, `done` rises in the cycle after `start` and both results are zero.
- R9: After `done`, the accumulator and the count clear and `bytes_left` is 0. Bytes offered while the block is idle are ignored.
- R10: A `start` pulse while collecting, including in the `done` cycle, begins a new instruction with the new sizes and discards the bytes already collected. When `start` and `byte_valid` are high in the same cycle, the byte is dropped.
- R11: After reset, `done` is 0, `bytes_left` is 0 and both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new instruction; loads the sizes and controls |
| disp_size | input | 2 | Displacement size code |
| imm_size | input | 2 | Immediate size code |
| data_size | input | 2 | Current data size code |
| disp_sext | input | 1 | Sign-extend a short displacement |
| imm_sext | input | 1 | Allow sign extension of the immediate |
| byte_valid | input | 1 | `byte_in` holds a stream byte |
| byte_in | input | 8 | Stream byte |
| disp_out | output | 32 | Extended displacement, valid while `done` |
| imm_out | output | 32 | Extended immediate, valid while `done` |
| done | output | 1 | One-cycle completion pulse |
| bytes_left | output | 4 | Bytes still required |

## Verification
Two pairs of events can collide in one cycle. A new `start` can arrive in the same cycle that the previous instruction's `done` is presented, and a `start` can arrive together with a valid byte. The bench provokes the first case by raising `start` at the exact cycle `done` is expected. It checks that the finished results are still correct in that cycle and that the next cycle shows the new byte count with `done` low. It provokes the second case by restarting in the middle of a collection while a byte is offered. It then checks that `bytes_left` reflects only the new sizes and that the dropped byte never appears in the result.

// File: rtl/asm_pkg.sv
package asm_pkg;

  typedef enum logic [1:0] {
    SZ_NONE  = 2'd0,
    SZ_BYTE  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  // Byte count carried by a size code
  function automatic logic [2:0] size_bytes(input size_e s);
    case (s)
      SZ_BYTE:  return 3'd1;
      SZ_WORD:  return 3'd2;
      SZ_DWORD: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/asm_extend.sv
module asm_extend
  import asm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] raw_i,
  input  size_e        size_i,
  input  logic         sext_i,
  output logic [W-1:0] val_o
);

  localparam int SH_W = $clog2(W + 1);

  logic [SH_W-1:0] n_bits;
  logic [SH_W-1:0] pad;
  logic [W-1:0]    mask;
  logic [W-1:0]    lifted;

  always_comb begin
    n_bits = SH_W'({size_bytes(size_i), 3'b000});
    pad    = SH_W'(W) - n_bits;
    mask   = ~({W{1'b1}} << n_bits);
    lifted = raw_i << pad;
    if (sext_i && n_bits != '0)
      val_o = W'($signed(lifted) >>> pad);
    else
      val_o = raw_i & mask;
  end

endmodule

// File: rtl/asm_collect.sv
module asm_collect #(
  parameter int ACC_BYTES = 8,
  localparam int ACC_W = ACC_BYTES * 8,
  localparam int CNT_W = $clog2(ACC_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] need_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             done_o,
  output logic [CNT_W-1:0] left_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] need_q, need_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             take;

  assign done_o = busy_q && (cnt_q == need_q);
  assign left_o = busy_q ? (need_q - cnt_q) : '0;
  assign acc_o  = acc_q;
  assign take   = busy_q && !done_o && byte_valid_i;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    need_d = need_q;
    acc_d  = acc_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      need_d = need_i;
      acc_d  = '0;
    end else if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      need_d = '0;
      acc_d  = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      for (int i = 0; i < ACC_BYTES; i++)
        if (cnt_q == CNT_W'(i)) acc_d[i*8 +: 8] = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      need_q <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      need_q <= need_d;
      acc_q  <= acc_d;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);

  // R6
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start_i) |=> (left_o == $past(left_o) - 1'b1));

  // R6
  left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_o && !byte_valid_i && !start_i) |=> $stable(left_o));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (left_o == '0 && acc_o == '0));

endmodule

// File: rtl/asm_trail.sv
module asm_trail
  import asm_pkg::*;
#(
  parameter int ACC_BYTES = 8,
  parameter int OUT_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  disp_size,
  input  logic [1:0]  imm_size,
  input  logic [1:0]  data_size,
  input  logic        disp_sext,
  input  logic        imm_sext,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  output logic [31:0] disp_out,
  output logic [31:0] imm_out,
  output logic        done,
  output logic [3:0]  bytes_left
);

  localparam int ACC_W = ACC_BYTES * 8;
  localparam int CNT_W = $clog2(ACC_BYTES + 1);
  localparam int SH_W  = $clog2(ACC_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // per-instruction configuration
  size_e dsz_q, dsz_d, isz_q, isz_d, dat_q, dat_d;
  logic  dsx_q, dsx_d, isx_q, isx_d;

  always_comb begin
    dsz_d = dsz_q;
    isz_d = isz_q;
    dat_d = dat_q;
    dsx_d = dsx_q;
    isx_d = isx_q;
    if (start) begin
      dsz_d = size_e'(disp_size);
      isz_d = size_e'(imm_size);
      dat_d = size_e'(data_size);
      dsx_d = disp_sext;
      isx_d = imm_sext;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dsz_q <= SZ_NONE;
      isz_q <= SZ_NONE;
      dat_q <= SZ_NONE;
      dsx_q <= 1'b0;
      isx_q <= 1'b0;
    end else begin
      dsz_q <= dsz_d;
      isz_q <= isz_d;
      dat_q <= dat_d;
      dsx_q <= dsx_d;
      isx_q <= isx_d;
    end
  end

  // total byte requirement from the incoming sizes
  logic [CNT_W-1:0] need;
  assign need = CNT_W'(size_bytes(size_e'(disp_size)))
              + CNT_W'(size_bytes(size_e'(imm_size)));

  logic [ACC_W-1:0] acc;
  logic             fin;
  logic [CNT_W-1:0] left;

  asm_collect #(.ACC_BYTES(ACC_BYTES)) u_collect (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (start),
    .need_i       (need),
    .byte_valid_i (byte_valid),
    .byte_i       (byte_in),
    .acc_o        (acc),
    .done_o       (fin),
    .left_o       (left)
  );

  // field split: immediate follows the displacement bytes
  logic [SH_W-1:0]  disp_shift;
  logic [ACC_W-1:0] rest;
  logic             imm_sx_en;
  logic [OUT_W-1:0] disp_ext, imm_ext;

  assign disp_shift = SH_W'({size_bytes(dsz_q), 3'b000});
  assign rest       = acc >> disp_shift;
  assign imm_sx_en  = isx_q && (isz_q != dat_q);

  asm_extend #(.W(OUT_W)) u_disp_ext (
    .raw_i  (acc[OUT_W-1:0]),
    .size_i (dsz_q),
    .sext_i (dsx_q),
    .val_o  (disp_ext)
  );

  asm_extend #(.W(OUT_W)) u_imm_ext (
    .raw_i  (rest[OUT_W-1:0]),
    .size_i (isz_q),
    .sext_i (imm_sx_en),
    .val_o  (imm_ext)
  );

  assign done       = fin;
  assign disp_out   = fin ? 32'(disp_ext) : '0;
  assign imm_out    = fin ? 32'(imm_ext) : '0;
  assign bytes_left = 4'(left);

  // R7
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done |-> (disp_out == '0 && imm_out == '0));

  // R5
  imm_zext_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && isz_q == SZ_BYTE && !imm_sx_en) |-> (imm_out[31:8] == '0));

  // R4
  disp_byte_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && dsz_q == SZ_BYTE && dsx_q) |-> (disp_out[31:8] == {24{disp_out[7]}}));

endmodule

// File: tb/asm_trail_tb.sv
`timescale 1ns/1ps
module asm_trail_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, disp_sext, imm_sext, byte_valid;
  logic [1:0]  disp_size, imm_size, data_size;
  logic [7:0]  byte_in;
  logic [31:0] disp_out, imm_out;
  logic        done;
  logic [3:0]  bytes_left;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  asm_trail u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .disp_size(disp_size), .imm_size(imm_size), .data_size(data_size),
    .disp_sext(disp_sext), .imm_sext(imm_sext),
    .byte_valid(byte_valid), .byte_in(byte_in),
    .disp_out(disp_out), .imm_out(imm_out),
    .done(done), .bytes_left(bytes_left)
  );

  typedef struct packed {
    logic [1:0]  dsz, isz, dat;
    logic        dsx, isx;
    logic [63:0] bytes;
    logic [31:0] edisp, eimm;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{2'd1, 2'd0, 2'd2, 1'b1, 1'b0, 64'h80,               32'hFFFFFF80, 32'h0},
    '{2'd1, 2'd0, 2'd2, 1'b0, 1'b0, 64'h80,               32'h00000080, 32'h0},
    '{2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 64'h85F234,           32'hFFFFF234, 32'hFFFFFF85},
    '{2'd0, 2'd1, 2'd1, 1'b0, 1'b1, 64'h85,               32'h0,        32'h00000085},
    '{2'd3, 2'd3, 2'd3, 1'b0, 1'b1, 64'h90ABCDEF12345678, 32'h12345678, 32'h90ABCDEF},
    '{2'd0, 2'd2, 2'd3, 1'b0, 1'b1, 64'hFFFE,             32'h0,        32'hFFFFFFFE},
    '{2'd0, 2'd2, 2'd3, 1'b0, 1'b0, 64'hFFFE,             32'h0,        32'h0000FFFE},
    '{2'd2, 2'd2, 2'd2, 1'b0, 1'b1, 64'h80018000,         32'h00008000, 32'h00008001},
    '{2'd1, 2'd3, 2'd3, 1'b1, 1'b1, 64'h810203047F,       32'h0000007F, 32'h81020304},
    '{2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 64'hF0,               32'h0,        32'h000000F0}
  };

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd3) ? 4 : int'(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] d, input logic [1:0] i, input logic [1:0] t,
                          input logic dx, input logic ix);
    start = 1'b1; disp_size = d; imm_size = i; data_size = t;
    disp_sext = dx; imm_sext = ix;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; byte_valid = 1'b0; byte_in = '0;
    disp_size = '0; imm_size = '0; data_size = '0; disp_sext = 1'b0; imm_sext = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 bytes_left", 32'(bytes_left), 32'd0);
    chk("R11 disp", disp_out, 32'd0);
    chk("R11 imm", imm_out, 32'd0);

    // R1 R2 R3 R4 R5 vector table
    foreach (VEC[k]) begin
      automatic int tot = nbytes(VEC[k].dsz) + nbytes(VEC[k].isz);
      do_start(VEC[k].dsz, VEC[k].isz, VEC[k].dat, VEC[k].dsx, VEC[k].isx);
      for (int i = 0; i < tot; i++) begin
        chk("R6 R1 bytes_left", 32'(bytes_left), 32'(tot - i));
        chk("R7 early done", 32'(done), 32'd0);
        send(VEC[k].bytes[i*8 +: 8]);
      end
      chk("R7 done", 32'(done), 32'd1);
      chk("R2 R3 R4 disp", disp_out, VEC[k].edisp);
      chk("R3 R5 imm", imm_out, VEC[k].eimm);
      @(negedge clk);
      chk("R7 pulse", 32'(done), 32'd0);
      chk("R9 cleared", 32'(bytes_left), 32'd0);
    end

    // R8 both sizes none
    do_start(2'd0, 2'd0, 2'd2, 1'b1, 1'b1);
    chk("R8 done", 32'(done), 32'd1);
    chk("R8 disp", disp_out, 32'd0);
    chk("R8 imm", imm_out, 32'd0);
    @(negedge clk);

    // R6 pause with byte_valid low
    do_start(2'd2, 2'd0, 2'd2, 1'b0, 1'b0);
    send(8'h34);
    for (int j = 0; j < 3; j++) begin
      chk("R6 hold", 32'(bytes_left), 32'd1);
      chk("R7 quiet disp", disp_out, 32'd0);
      @(negedge clk);
    end
    send(8'h92);
    chk("R6 resume done", 32'(done), 32'd1);
    chk("R6 resume disp", disp_out, 32'h00009234);
    @(negedge clk);

    // R9 idle bytes ignored
    for (int j = 0; j < 2; j++) begin
      send(8'hAA);
      chk("R9 idle left", 32'(bytes_left), 32'd0);
      chk("R9 idle done", 32'(done), 32'd0);
    end
    do_start(2'd1, 2'd0, 2'd2, 1'b0, 1'b0);
    chk("R9 fresh left", 32'(bytes_left), 32'd1);
    send(8'h11);
    chk("R9 fresh disp", disp_out, 32'h00000011);
    @(negedge clk);

    // R10 restart mid-collection with a byte in the same cycle
    do_start(2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
    send(8'h01);
    send(8'h02);
    byte_valid = 1'b1; byte_in = 8'hEE;
    do_start(2'd1, 2'd0, 2'd2, 1'b0, 1'b0);
    byte_valid = 1'b0;
    chk("R10 restart left", 32'(bytes_left), 32'd1);
    send(8'h22);
    chk("R10 restart done", 32'(done), 32'd1);
    chk("R10 restart disp", disp_out, 32'h00000022);
    @(negedge clk);

    // R10 start in the done cycle
    do_start(2'd1, 2'd0, 2'd2, 1'b0, 1'b0);
    send(8'h33);
    chk("R10 overlap done", 32'(done), 32'd1);
    chk("R10 overlap disp", disp_out, 32'h00000033);
    do_start(2'd0, 2'd1, 2'd1, 1'b0, 1'b1);
    chk("R10 overlap next done", 32'(done), 32'd0);
    chk("R10 overlap next left", 32'(bytes_left), 32'd1);
    send(8'h44);
    chk("R10 overlap imm", imm_out, 32'h00000044);
    @(negedge clk);

    finish_run();
  end

endmodule